// File: doc/BRIEF.md
# Core Voltage Window Monitor

This block supervises the core output of a programmable buck regulator. A five-bit voltage-identification code names the wanted core level. The block turns that code into a setpoint in millivolts. It then compares each digitized core sample against percentage bands of that setpoint. From these comparisons it drives three outputs: a power-good flag with hysteresis, an overvoltage trip flag, and a shutdown request for the reserved all-ones code.

Samples arrive as unsigned millivolt words on a valid/data handshake. Three undervoltage flags from the auxiliary linear rails are sampled with each core sample. A sequencer holds `run_en` low while it restarts the regulator. During that time the code is captured on every cycle. Once `run_en` is high, the captured setpoint is frozen and later code changes have no effect until the next restart.

Top module: `vid_window_monitor`

## Requirements
- R1: With code bit 4 at 0, the low four bits F give a setpoint of 1300 + (15 − F) × 50 mV. For example, 01111 gives 1300, 01011 gives 1500 and 00000 gives 2050.
- R2: With code bit 4 at 1 and the code not 11111, the setpoint is 2000 + (15 − F) × 100 mV. For example, 11110 gives 2100 and 10000 gives 3500.
- R3: While the captured code is 11111, `shdn_req` is 1. After the next valid sample, `pg_ok` is 1 (released), whatever the sample value.
- R4: While power-good is in-window, a sample above ⌊SP×110/100⌋ or below ⌊SP×92/100⌋ drops `pg_ok` to 0.
- R5: While power-good is out-of-window, it returns only for a sample that is at most ⌊SP×108/100⌋ and at least ⌊SP×94/100⌋. These are the 2% hysteresis limits.
- R6: A sample taken while any `aux_uv` bit is 1 gives `pg_ok` = 0. The window state is still tracked during such a sample.
- R7: `ov_trip` is 1 after a sample above ⌊SP×115/100⌋. It is 0 after a sample at or below that level.
- R8: The setpoint is loaded from `vid_code` on every clock while `run_en` is 0. It holds while `run_en` is 1.
- R9: Outputs change one clock after a sample with `s_valid` = 1. Without `s_valid`, outputs hold regardless of `s_mv` and `aux_uv`.
- R10: During reset, `pg_ok`, `ov_trip` and `shdn_req` are 0, and `setpoint_mv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Sequencer run enable; low captures the code |
| vid_code | input | 5 | Voltage-identification code |
| s_valid | input | 1 | Core sample valid |
| s_mv | input | 13 | Core sample in millivolts |
| aux_uv | input | 3 | Auxiliary rail undervoltage flags |
| pg_ok | output | 1 | Power-good (1 = good or released) |
| ov_trip | output | 1 | Core overvoltage flag |
| shdn_req | output | 1 | Shutdown request for code 11111 |
| setpoint_mv | output | 13 | Captured setpoint in millivolts |

## Verification
The assertions assume two things about the inputs. First, `s_mv` and the decoded setpoint fit in 13 bits. Second, the thresholds they check are derived from the setpoint already registered in the cycle of the sample, so a sample taken in the same cycle that a new code loads is judged against the old setpoint. The stimulus respects this ordering. It changes the code only with `run_en` low and no sample pending. It raises `run_en` before presenting samples. It keeps all sample values below 8192 mV.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
    localparam int unsigned MV_W   = 13;
    localparam int unsigned CODE_W = 5;

    typedef logic [MV_W-1:0] mv_t;

    typedef struct packed {
        mv_t hi;     // drop above
        mv_t lo;     // drop below
        mv_t rehi;   // re-enter at or below
        mv_t relo;   // re-enter at or above
        mv_t ov;     // overvoltage above
    } thr_t;

    function automatic mv_t pct_of(mv_t base, int unsigned pct);
        logic [31:0] prod;
        prod = 32'(base) * 32'(pct);
        return mv_t'(prod / 32'd100);
    endfunction
endpackage

// File: rtl/vwm_sp_decode.sv
module vwm_sp_decode
    import vwm_pkg::*;
#(
    parameter int unsigned BASE_LO = 1300,
    parameter int unsigned STEP_LO = 50,
    parameter int unsigned BASE_HI = 2000,
    parameter int unsigned STEP_HI = 100
) (
    input  logic [CODE_W-1:0] code,
    output mv_t               sp_mv,
    output logic              inhibit
);
    localparam int unsigned FW     = CODE_W - 1;
    localparam int unsigned FMAX   = (1 << FW) - 1;

    logic [FW-1:0] field;
    logic [31:0]   steps;

    always_comb begin
        field   = code[FW-1:0];
        steps   = 32'(FMAX) - 32'(field);
        inhibit = &code;
        if (code[CODE_W-1])
            sp_mv = mv_t'(32'(BASE_HI) + steps * 32'(STEP_HI));
        else
            sp_mv = mv_t'(32'(BASE_LO) + steps * 32'(STEP_LO));
    end
endmodule

// File: rtl/vwm_thresholds.sv
module vwm_thresholds
    import vwm_pkg::*;
#(
    parameter int unsigned HI_PCT   = 110,
    parameter int unsigned LO_PCT   = 92,
    parameter int unsigned HYST_PCT = 2,
    parameter int unsigned OV_PCT   = 115
) (
    input  mv_t  sp_mv,
    output thr_t thr
);
    localparam int unsigned REHI_PCT = HI_PCT - HYST_PCT;
    localparam int unsigned RELO_PCT = LO_PCT + HYST_PCT;

    always_comb begin
        thr.hi   = pct_of(sp_mv, HI_PCT);
        thr.lo   = pct_of(sp_mv, LO_PCT);
        thr.rehi = pct_of(sp_mv, REHI_PCT);
        thr.relo = pct_of(sp_mv, RELO_PCT);
        thr.ov   = pct_of(sp_mv, OV_PCT);
    end
endmodule

// File: rtl/vwm_window.sv
module vwm_window
    import vwm_pkg::*;
(
    input  mv_t  mv,
    input  thr_t thr,
    input  logic win_q,
    output logic win_d,
    output logic ov_hit
);
    logic outside, inside_tight;

    always_comb begin
        outside      = (mv > thr.hi) || (mv < thr.lo);
        inside_tight = (mv <= thr.rehi) && (mv >= thr.relo);
        win_d        = win_q ? !outside : inside_tight;
        ov_hit       = mv > thr.ov;
    end
endmodule

// File: rtl/vid_window_monitor.sv
module vid_window_monitor
    import vwm_pkg::*;
#(
    parameter int unsigned NUM_AUX  = 3,
    parameter int unsigned HI_PCT   = 110,
    parameter int unsigned LO_PCT   = 92,
    parameter int unsigned HYST_PCT = 2,
    parameter int unsigned OV_PCT   = 115
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic [CODE_W-1:0]  vid_code,
    input  logic               s_valid,
    input  logic [MV_W-1:0]    s_mv,
    input  logic [NUM_AUX-1:0] aux_uv,
    output logic               pg_ok,
    output logic               ov_trip,
    output logic               shdn_req,
    output logic [MV_W-1:0]    setpoint_mv
);
    typedef struct packed {
        mv_t  sp;
        logic inh;
        logic win;
        logic pg;
        logic ov;
    } st_t;

    st_t  st_d, st_q;
    mv_t  dec_mv;
    logic dec_inh;
    thr_t thr;
    logic win_d, ov_hit;

    vwm_sp_decode u_dec (
        .code    (vid_code),
        .sp_mv   (dec_mv),
        .inhibit (dec_inh)
    );

    vwm_thresholds #(
        .HI_PCT   (HI_PCT),
        .LO_PCT   (LO_PCT),
        .HYST_PCT (HYST_PCT),
        .OV_PCT   (OV_PCT)
    ) u_thr (
        .sp_mv (st_q.sp),
        .thr   (thr)
    );

    vwm_window u_win (
        .mv     (s_mv),
        .thr    (thr),
        .win_q  (st_q.win),
        .win_d  (win_d),
        .ov_hit (ov_hit)
    );

    always_comb begin
        st_d = st_q;
        if (!run_en) begin
            st_d.sp  = dec_mv;
            st_d.inh = dec_inh;
        end
        if (s_valid) begin
            st_d.win = win_d;
            st_d.ov  = ov_hit;
            st_d.pg  = st_q.inh ? 1'b1 : (win_d && !(|aux_uv));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pg_ok       = st_q.pg;
    assign ov_trip     = st_q.ov;
    assign shdn_req    = st_q.inh;
    assign setpoint_mv = st_q.sp;

    a_r4_drop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !shdn_req && s_mv > thr.hi) |=> !pg_ok);

    a_r6_aux_blocks_pg: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !shdn_req && (|aux_uv)) |=> !pg_ok);

    a_r7_ov_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_mv > thr.ov) |=> ov_trip);

    a_r8_sp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $past(run_en)) |-> $stable(setpoint_mv));

    a_r9_hold_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !s_valid |=> ($stable(pg_ok) && $stable(ov_trip)));

    a_r3_inhibit_release: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && shdn_req) |=> pg_ok);
endmodule

// File: tb/vid_window_monitor_tb.sv
module vid_window_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [4:0]  vid_code = 5'b01111;
    logic        s_valid = 1'b0;
    logic [12:0] s_mv = '0;
    logic [2:0]  aux_uv = '0;
    logic        pg_ok, ov_trip, shdn_req;
    logic [12:0] setpoint_mv;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vid_window_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .vid_code(vid_code),
        .s_valid(s_valid), .s_mv(s_mv), .aux_uv(aux_uv),
        .pg_ok(pg_ok), .ov_trip(ov_trip), .shdn_req(shdn_req),
        .setpoint_mv(setpoint_mv)
    );

    function automatic int exp_sp(logic [4:0] c);
        int f = int'(c[3:0]);
        return c[4] ? 2000 + (15 - f) * 100 : 1300 + (15 - f) * 50;
    endfunction

    function automatic int pct(int sp, int p);
        return (sp * p) / 100;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_code(logic [4:0] c);
        @(negedge clk); run_en = 1'b0; vid_code = c;
        @(negedge clk); run_en = 1'b1;
    endtask

    task automatic sample(int mv, logic [2:0] a);
        @(negedge clk); s_valid = 1'b1; s_mv = 13'(mv); aux_uv = a;
        @(negedge clk); s_valid = 1'b0; aux_uv = '0;
    endtask

    task automatic t_reset();
        chk("R10 pg", int'(pg_ok), 0);
        chk("R10 ov", int'(ov_trip), 0);
        chk("R10 shdn", int'(shdn_req), 0);
        chk("R10 sp", int'(setpoint_mv), 0);
    endtask

    task automatic t_decode();
        logic [4:0] codes [6] = '{5'b01111, 5'b01011, 5'b00000, 5'b01010, 5'b11110, 5'b10000};
        foreach (codes[i]) begin
            load_code(codes[i]);
            if (codes[i][4]) chk("R2 decode", int'(setpoint_mv), exp_sp(codes[i]));
            else             chk("R1 decode", int'(setpoint_mv), exp_sp(codes[i]));
        end
        load_code(5'b10101);
        chk("R2 decode 3000", int'(setpoint_mv), 3000);
        chk("R2 not inhibit", int'(shdn_req), 0);
    endtask

    task automatic t_window();
        int sp;
        load_code(5'b01011);
        sp = exp_sp(5'b01011);
        sample(sp, 3'b000);                 chk("R5 enter nominal", int'(pg_ok), 1);
        sample(pct(sp, 110), 3'b000);       chk("R4 at hi edge", int'(pg_ok), 1);
        sample(pct(sp, 110) + 1, 3'b000);   chk("R4 above hi", int'(pg_ok), 0);
        sample(pct(sp, 108) + 1, 3'b000);   chk("R5 above rehi", int'(pg_ok), 0);
        sample(pct(sp, 108), 3'b000);       chk("R5 at rehi", int'(pg_ok), 1);
        sample(pct(sp, 92), 3'b000);        chk("R4 at lo edge", int'(pg_ok), 1);
        sample(pct(sp, 92) - 1, 3'b000);    chk("R4 below lo", int'(pg_ok), 0);
        sample(pct(sp, 94) - 1, 3'b000);    chk("R5 below relo", int'(pg_ok), 0);
        sample(pct(sp, 94), 3'b000);        chk("R5 at relo", int'(pg_ok), 1);
        // R9: no valid -> no change
        @(negedge clk); s_mv = 13'd100; aux_uv = 3'b111;
        @(negedge clk); @(negedge clk);
        chk("R9 hold pg", int'(pg_ok), 1);
        chk("R9 hold ov", int'(ov_trip), 0);
        aux_uv = '0;
    endtask

    task automatic t_aux();
        int sp = int'(setpoint_mv);
        for (int b = 0; b < 3; b++) begin
            sample(sp, 3'(1 << b));         chk("R6 aux flag", int'(pg_ok), 0);
        end
        sample(sp, 3'b000);                 chk("R6 aux clear", int'(pg_ok), 1);
    endtask

    task automatic t_ov();
        int sp = int'(setpoint_mv);
        sample(pct(sp, 115), 3'b000);       chk("R7 at ov edge", int'(ov_trip), 0);
        sample(pct(sp, 115) + 1, 3'b000);   chk("R7 above ov", int'(ov_trip), 1);
        sample(sp, 3'b000);                 chk("R7 clear", int'(ov_trip), 0);
    endtask

    task automatic t_inhibit();
        load_code(5'b11111);
        chk("R3 shdn", int'(shdn_req), 1);
        sample(400, 3'b101);                chk("R3 pg released", int'(pg_ok), 1);
        load_code(5'b01011);
        chk("R3 shdn clear", int'(shdn_req), 0);
    endtask

    task automatic t_freeze();
        int sp;
        load_code(5'b01011);
        sp = exp_sp(5'b01011);
        sample(sp, 3'b000);
        @(negedge clk); vid_code = 5'b10000;
        @(negedge clk); @(negedge clk);
        chk("R8 sp frozen", int'(setpoint_mv), sp);
        sample(pct(sp, 110) + 1, 3'b000);   chk("R8 old thresholds", int'(pg_ok), 0);
        @(negedge clk); run_en = 1'b0;
        @(negedge clk); run_en = 1'b1;
        chk("R8 reload", int'(setpoint_mv), 3500);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_decode();
        t_window();
        t_aux();
        t_ov();
        t_inhibit();
        t_freeze();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule